// File: doc/BRIEF.md
# Rear-Module Hot-Swap Power Sequencer

This block brings power up and down on a rear transition module that has no controller of its own. It follows the host's hot-swap states M0 to M4. On insertion it enables management power and waits for management power-good within a timeout given in milliseconds. It then waits for the handle switch to close. On the host's activate request it enables payload power and the I2C buffer, and enters M4 once payload power-good arrives.

A missing power-good, or a loss of management power-good once the module is past M1, is a failure. On a failure the block drops every enable, returns to M0 and raises a sticky dead flag that blocks any new power-up. The flag clears only when the module is pulled out. Removing the module at any point drops every enable at once without raising the flag. A blue LED shows that the module is not yet active. The green LED shows that it is active, and the red LED records the last power-on failure. Each enable pin and each power-good pin can be inverted by its own configuration bit.

Top module: `rtm_pwr_seq`

## Requirements
- R1: After reset, `mstate` is 0 (binary code of the M-state, 0 to 4), every enable is inactive, `dead`, `led_red` and `led_green` are 0, and `led_blue` is 1.
- R2: Presence is active low on `pres_n_pin`; it passes a two-flop synchronizer and a debounce of DEB_CYC stable cycles. Presence in M0 with `dead` clear moves to M1, where management-power enable is active.
- R3: M1 moves to M2 only when management power-good and the handle switch (`handle_pin`, high = closed) are both seen; `act_req` in M1 has no effect.
- R4: `act_req` in M2 moves to M3; payload enable and `i2c_buf_en` are active only in M3 and M4; payload power-good in M3 moves to M4.
- R5: If management power-good is not seen within `cfg_timeout_ms` ticks (one tick every TICK_DIV clocks) of entering M1, the block drops management enable, sets `dead` and returns to M0; it never fails before `cfg_timeout_ms`-1 full ticks.
- R6: If payload power-good is not seen within `cfg_timeout_ms` ticks of entering M3, the same failure occurs.
- R7: Loss of management power-good in M2, M3 or M4 is a failure: M0, `dead` set, all enables inactive.
- R8: Loss of presence in any state returns to M0 with all enables inactive and does not set `dead`.
- R9: While `dead` is set and the module stays present, the block stays in M0; `dead` clears when presence goes away, and a reinsertion then enters M1.
- R10: `cfg_inv` bit 0 inverts the management enable pin, bit 1 the management power-good pin, bit 2 the payload enable pin, bit 3 the payload power-good pin; `i2c_buf_en` and presence are never inverted.
- R11: `led_blue` is on in M0 to M3 and off in M4; `led_green` is on only in M4 and is off again after a return to M1.
- R12: `led_red` is set by any failure and cleared when the block reaches M4.
- R13: `deact_req` in M4 returns to M1, drops payload enable and `i2c_buf_en`, and keeps management enable active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pres_n_pin | input | 1 | Presence detect, active low |
| handle_pin | input | 1 | Handle switch, high when closed |
| mp_good_pin | input | 1 | Management power-good pin |
| pp_good_pin | input | 1 | Payload power-good pin |
| act_req | input | 1 | Host activate request, one-cycle pulse |
| deact_req | input | 1 | Host deactivate request, one-cycle pulse |
| cfg_inv | input | 4 | Per-pin polarity inversion bits |
| cfg_timeout_ms | input | TMO_W | Power-good timeout in milliseconds |
| mp_en_pin | output | 1 | Management power enable pin |
| pp_en_pin | output | 1 | Payload power enable pin |
| i2c_buf_en | output | 1 | I2C buffer enable, active high |
| led_blue | output | 1 | Hot-swap LED |
| led_red | output | 1 | Failure LED |
| led_green | output | 1 | Active LED |
| mstate | output | 3 | Current M-state, 0 to 4 |
| dead | output | 1 | Sticky failure flag |

## Verification
The bench probes the timeout window from both sides. A timer that starts late or counts the wrong unit either fails while the module is still inside its allowed wait, or leaves it stuck in M1 or M3 forever. The dead flag is held with the module present and power-good back. A flag that clears itself would show up as an unexpected transition to M1 in the scoreboard. The bench also removes the module, and a flag that never clears would block the next insertion. A management power-good drop in M2 and in M4 with all pins inverted catches a failure check tied to the wrong state or to the raw pin level. A deactivate from M4 catches a design that drops management power or leaves the green LED on.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
   typedef enum logic [2:0] {
      ST_M0 = 3'd0,
      ST_M1 = 3'd1,
      ST_M2 = 3'd2,
      ST_M3 = 3'd3,
      ST_M4 = 3'd4
   } hs_state_t;

   localparam int NUM_IN   = 4;
   localparam int IDX_PRES = 0;
   localparam int IDX_HDL  = 1;
   localparam int IDX_MPG  = 2;
   localparam int IDX_PPG  = 3;
endpackage

// File: rtl/rtm_tick_gen.sv
module rtm_tick_gen #(
   parameter int TICK_DIV = 50000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic [CW-1:0] cnt;

   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("rtm_tick_gen: TICK_DIV must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt == CW'(TICK_DIV - 1)) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/rtm_in_cond.sv
module rtm_in_cond #(
   parameter bit DEBOUNCE = 1'b1,
   parameter int DEB_CYC  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic lvl
);
   localparam int CW = $clog2(DEB_CYC + 1);

   logic s1, s2;

   generate
      if (DEB_CYC < 1) begin : g_bad_deb
         $error("rtm_in_cond: DEB_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b0;
         s2 <= 1'b0;
      end else begin
         s1 <= raw;
         s2 <= s1;
      end
   end

   generate
      if (DEBOUNCE) begin : g_deb
         logic [CW-1:0] cnt;
         logic          stab;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               stab <= 1'b0;
            end else if (s2 == stab) begin
               cnt <= '0;
            end else if (cnt == CW'(DEB_CYC - 1)) begin
               cnt  <= '0;
               stab <= s2;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign lvl = stab;
      end else begin : g_sync_only
         assign lvl = s2;
      end
   endgenerate
endmodule

// File: rtl/rtm_seq_fsm.sv
module rtm_seq_fsm
   import rtm_pkg::*;
#(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             present,
   input  logic             handle,
   input  logic             mp_good,
   input  logic             pp_good,
   input  logic             act_req,
   input  logic             deact_req,
   input  logic [TMO_W-1:0] tmo_ms,
   output hs_state_t        state,
   output logic             dead,
   output logic             red
);
   hs_state_t        nxt;
   logic             fail;
   logic             mp_seen;
   logic [TMO_W-1:0] tcnt;
   logic             tmo;

   assign tmo = (tcnt >= tmo_ms);

   always_comb begin
      nxt  = state;
      fail = 1'b0;
      unique case (state)
         ST_M0: if (!dead) nxt = ST_M1;
         ST_M1: begin
            if (mp_good && handle) nxt = ST_M2;
            else if (!mp_seen && !mp_good && tmo) fail = 1'b1;
         end
         ST_M2: begin
            if (!mp_good) fail = 1'b1;
            else if (act_req) nxt = ST_M3;
         end
         ST_M3: begin
            if (!mp_good) fail = 1'b1;
            else if (pp_good) nxt = ST_M4;
            else if (tmo) fail = 1'b1;
         end
         ST_M4: begin
            if (!mp_good) fail = 1'b1;
            else if (deact_req) nxt = ST_M1;
         end
         default: nxt = ST_M0;
      endcase
      if (!present) begin
         nxt  = ST_M0;
         fail = 1'b0;
      end else if (fail) begin
         nxt = ST_M0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_M0;
         dead    <= 1'b0;
         red     <= 1'b0;
         mp_seen <= 1'b0;
         tcnt    <= '0;
      end else begin
         state <= nxt;
         if (nxt != state) tcnt <= '0;
         else if (tick && !tmo) tcnt <= tcnt + 1'b1;
         if (nxt != ST_M1) mp_seen <= 1'b0;
         else if (mp_good) mp_seen <= 1'b1;
         if (!present) dead <= 1'b0;
         else if (fail) dead <= 1'b1;
         if (fail) red <= 1'b1;
         else if (nxt == ST_M4 && state != ST_M4) red <= 1'b0;
      end
   end
endmodule

// File: rtl/rtm_pwr_seq.sv
module rtm_pwr_seq
   import rtm_pkg::*;
#(
   parameter int TICK_DIV = 50000,
   parameter int DEB_CYC  = 16,
   parameter int TMO_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pres_n_pin,
   input  logic             handle_pin,
   input  logic             mp_good_pin,
   input  logic             pp_good_pin,
   input  logic             act_req,
   input  logic             deact_req,
   input  logic [3:0]       cfg_inv,
   input  logic [TMO_W-1:0] cfg_timeout_ms,
   output logic             mp_en_pin,
   output logic             pp_en_pin,
   output logic             i2c_buf_en,
   output logic             led_blue,
   output logic             led_red,
   output logic             led_green,
   output logic [2:0]       mstate,
   output logic             dead
);
   logic [NUM_IN-1:0] raw_in;
   logic [NUM_IN-1:0] cond_lvl;
   logic              tick;
   hs_state_t         st;
   logic              mp_en_l, pp_en_l;

   generate
      if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo
         $error("rtm_pwr_seq: TMO_W must be 1 to 32");
      end
   endgenerate

   assign raw_in[IDX_PRES] = ~pres_n_pin;
   assign raw_in[IDX_HDL]  = handle_pin;
   assign raw_in[IDX_MPG]  = mp_good_pin ^ cfg_inv[1];
   assign raw_in[IDX_PPG]  = pp_good_pin ^ cfg_inv[3];

   for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      rtm_in_cond #(
         .DEBOUNCE (i == IDX_PRES || i == IDX_HDL),
         .DEB_CYC  (DEB_CYC)
      ) u_cond (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (raw_in[i]),
         .lvl   (cond_lvl[i])
      );
   end

   rtm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   rtm_seq_fsm #(.TMO_W(TMO_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .present   (cond_lvl[IDX_PRES]),
      .handle    (cond_lvl[IDX_HDL]),
      .mp_good   (cond_lvl[IDX_MPG]),
      .pp_good   (cond_lvl[IDX_PPG]),
      .act_req   (act_req),
      .deact_req (deact_req),
      .tmo_ms    (cfg_timeout_ms),
      .state     (st),
      .dead      (dead),
      .red       (led_red)
   );

   assign mp_en_l    = (st != ST_M0);
   assign pp_en_l    = (st == ST_M3) || (st == ST_M4);
   assign mp_en_pin  = mp_en_l ^ cfg_inv[0];
   assign pp_en_pin  = pp_en_l ^ cfg_inv[2];
   assign i2c_buf_en = pp_en_l;
   assign led_blue   = (st != ST_M4);
   assign led_green  = (st == ST_M4);
   assign mstate     = st;
endmodule

// File: rtl/rtm_pwr_seq_chk.sv
module rtm_pwr_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] cfg_inv,
   input logic       mp_en_pin,
   input logic       pp_en_pin,
   input logic       i2c_buf_en,
   input logic       led_blue,
   input logic       led_red,
   input logic       led_green,
   input logic [2:0] mstate,
   input logic       dead,
   input logic       present,
   input logic       pp_good
);
   logic mp_on, pp_on;
   assign mp_on = mp_en_pin ^ cfg_inv[0];
   assign pp_on = pp_en_pin ^ cfg_inv[2];

   AST_M0_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mstate == 3'd0) |-> (!mp_on && !pp_on && !i2c_buf_en)); // R8
   AST_PP_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_on || i2c_buf_en) |-> (mstate == 3'd3 || mstate == 3'd4)); // R4
   AST_PRES_LOSS_M0: assert property (@(posedge clk) disable iff (!rst_n)
      !present |=> (mstate == 3'd0)); // R8
   AST_DEAD_AT_M0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dead) |-> (mstate == 3'd0 && led_red)); // R5
   AST_DEAD_CLEAR_REMOVAL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dead) |-> !$past(present)); // R9
   AST_DEAD_HOLDS_M0: assert property (@(posedge clk) disable iff (!rst_n)
      dead |-> (mstate == 3'd0)); // R9
   AST_LED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      led_blue != led_green); // R11
   AST_M4_NEEDS_PPG: assert property (@(posedge clk) disable iff (!rst_n)
      (mstate == 3'd4 && $past(mstate) == 3'd3) |-> $past(pp_good)); // R4
   AST_RED_OFF_IN_M4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(led_green) |-> !led_red); // R12
endmodule

bind rtm_pwr_seq rtm_pwr_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_inv    (cfg_inv),
   .mp_en_pin  (mp_en_pin),
   .pp_en_pin  (pp_en_pin),
   .i2c_buf_en (i2c_buf_en),
   .led_blue   (led_blue),
   .led_red    (led_red),
   .led_green  (led_green),
   .mstate     (mstate),
   .dead       (dead),
   .present    (cond_lvl[0]),
   .pp_good    (cond_lvl[3])
);

// File: tb/rtm_pwr_seq_bench.sv
`timescale 1ns/1ps
module rtm_pwr_seq_bench;
   localparam int TMO_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pres_n_pin = 1'b1;
   logic             handle_pin = 1'b0;
   logic             mp_good_pin = 1'b0;
   logic             pp_good_pin = 1'b0;
   logic             act_req = 1'b0;
   logic             deact_req = 1'b0;
   logic [3:0]       cfg_inv = 4'h0;
   logic [TMO_W-1:0] cfg_timeout_ms = 16'd5;
   logic             mp_en_pin, pp_en_pin, i2c_buf_en;
   logic             led_blue, led_red, led_green, dead;
   logic [2:0]       mstate;

   always #10 clk = ~clk;

   rtm_pwr_seq #(.TICK_DIV(20), .DEB_CYC(4), .TMO_W(TMO_W)) u_rtm_pwr_seq (
      .clk(clk), .rst_n(rst_n), .pres_n_pin(pres_n_pin), .handle_pin(handle_pin),
      .mp_good_pin(mp_good_pin), .pp_good_pin(pp_good_pin), .act_req(act_req),
      .deact_req(deact_req), .cfg_inv(cfg_inv), .cfg_timeout_ms(cfg_timeout_ms),
      .mp_en_pin(mp_en_pin), .pp_en_pin(pp_en_pin), .i2c_buf_en(i2c_buf_en),
      .led_blue(led_blue), .led_red(led_red), .led_green(led_green),
      .mstate(mstate), .dead(dead));

   int n_chk = 0;
   int n_bad = 0;
   bit mon_en = 1'b0;
   bit done = 1'b0;
   logic [2:0] last_st = 3'd0;
   logic [2:0] q_st[$];
   logic       q_dk[$];
   string      q_tag[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [2:0] st, input logic dk, input string tag);
      q_st.push_back(st);
      q_dk.push_back(dk);
      q_tag.push_back(tag);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pres(input bit on);
      @(negedge clk) pres_n_pin = !on;
   endtask

   task automatic pulse_act();
      @(negedge clk) act_req = 1'b1;
      @(negedge clk) act_req = 1'b0;
   endtask

   task automatic pulse_deact();
      @(negedge clk) deact_req = 1'b1;
      @(negedge clk) deact_req = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // scoreboard monitor: every state change is compared with the next expected item
   always @(negedge clk) begin
      if (mon_en && mstate !== last_st) begin
         if (q_st.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL unexpected transition: actual %0d expected %0d", mstate, last_st);
         end else begin
            string t;
            logic [2:0] es;
            logic ed;
            es = q_st.pop_front();
            ed = q_dk.pop_front();
            t  = q_tag.pop_front();
            chk({t, " state"}, 32'(mstate), 32'(es));
            chk({t, " dead"}, 32'(dead), 32'(ed));
         end
         last_st = mstate;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
      end
   end

   initial begin
      cyc(5);
      @(negedge clk) rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 mstate", 32'(mstate), 0);
      chk("R1 mp_en", 32'(mp_en_pin), 0);
      chk("R1 pp_en", 32'(pp_en_pin), 0);
      chk("R1 i2c", 32'(i2c_buf_en), 0);
      chk("R1 dead", 32'(dead), 0);
      chk("R1 red", 32'(led_red), 0);
      chk("R1 green", 32'(led_green), 0);
      chk("R1 blue", 32'(led_blue), 1);
      mon_en = 1'b1;

      // R2 R3 R4 R11 R13 normal power-up and deactivation
      mp_good_pin = 1'b1;
      push(3'd1, 1'b0, "R2 insert");
      pres(1'b1); cyc(12);
      chk("R2 mp_en in M1", 32'(mp_en_pin), 1);
      chk("R4 pp_en off in M1", 32'(pp_en_pin), 0);
      pulse_act(); cyc(4);
      chk("R3 act ignored in M1", 32'(mstate), 1);
      push(3'd2, 1'b0, "R3 handle");
      handle_pin = 1'b1; cyc(12);
      chk("R3 in M2", 32'(mstate), 2);
      push(3'd3, 1'b0, "R4 activate");
      pulse_act(); cyc(2);
      chk("R4 pp_en in M3", 32'(pp_en_pin), 1);
      chk("R4 i2c in M3", 32'(i2c_buf_en), 1);
      push(3'd4, 1'b0, "R4 pp good");
      pp_good_pin = 1'b1; cyc(6);
      chk("R11 green in M4", 32'(led_green), 1);
      chk("R11 blue off in M4", 32'(led_blue), 0);
      push(3'd1, 1'b0, "R13 deactivate");
      push(3'd2, 1'b0, "R3 reenter M2");
      pulse_deact();
      chk("R13 pp_en off", 32'(pp_en_pin), 0);
      chk("R13 i2c off", 32'(i2c_buf_en), 0);
      chk("R13 mp_en kept", 32'(mp_en_pin), 1);
      chk("R11 green off in M1", 32'(led_green), 0);
      chk("R11 blue on in M1", 32'(led_blue), 1);
      cyc(3);

      // R7 management power-good loss in M2
      push(3'd0, 1'b1, "R7 mp loss");
      mp_good_pin = 1'b0; cyc(6);
      chk("R7 dead", 32'(dead), 1);
      chk("R7 red", 32'(led_red), 1);
      chk("R7 mp_en off", 32'(mp_en_pin), 0);

      // R9 dead is sticky while present
      mp_good_pin = 1'b1; cyc(200);
      chk("R9 stays M0", 32'(mstate), 0);
      chk("R9 dead held", 32'(dead), 1);
      pres(1'b0); cyc(12);
      chk("R9 dead cleared on removal", 32'(dead), 0);
      handle_pin = 1'b0;
      push(3'd1, 1'b0, "R9 reinsert");
      pres(1'b1); cyc(12);
      chk("R9 reinsert M1", 32'(mstate), 1);

      // R8 removal from M1, R5 management power-good timeout
      push(3'd0, 1'b0, "R8 removal");
      pres(1'b0); cyc(12);
      chk("R8 no dead on removal", 32'(dead), 0);
      mp_good_pin = 1'b0;
      push(3'd1, 1'b0, "R5 insert");
      push(3'd0, 1'b1, "R5 mp timeout");
      pres(1'b1); cyc(72);
      chk("R5 still waiting", 32'(mstate), 1);
      cyc(60);
      chk("R5 failed", 32'(mstate), 0);
      chk("R5 dead", 32'(dead), 1);
      chk("R5 mp_en off", 32'(mp_en_pin), 0);

      // R6 payload power-good timeout
      pres(1'b0); cyc(12);
      chk("R9 dead cleared", 32'(dead), 0);
      mp_good_pin = 1'b1; handle_pin = 1'b1; pp_good_pin = 1'b0;
      push(3'd1, 1'b0, "R6 insert");
      push(3'd2, 1'b0, "R6 handle");
      pres(1'b1); cyc(20);
      push(3'd3, 1'b0, "R6 activate");
      push(3'd0, 1'b1, "R6 pp timeout");
      pulse_act(); cyc(60);
      chk("R6 still waiting", 32'(mstate), 3);
      cyc(60);
      chk("R6 failed", 32'(mstate), 0);
      chk("R6 pp_en off", 32'(pp_en_pin), 0);
      chk("R12 red set", 32'(led_red), 1);

      // R12 red cleared by a successful power-up
      pres(1'b0); cyc(12);
      push(3'd1, 1'b0, "R12 insert");
      push(3'd2, 1'b0, "R12 handle");
      pres(1'b1); cyc(20);
      push(3'd3, 1'b0, "R12 activate");
      pulse_act(); cyc(2);
      chk("R12 red held before M4", 32'(led_red), 1);
      push(3'd4, 1'b0, "R12 active");
      pp_good_pin = 1'b1; cyc(6);
      chk("R12 red cleared", 32'(led_red), 0);

      // R8 removal from M4
      push(3'd0, 1'b0, "R8 removal M4");
      pres(1'b0); cyc(12);
      chk("R8 mp_en off", 32'(mp_en_pin), 0);
      chk("R8 pp_en off", 32'(pp_en_pin), 0);
      chk("R8 i2c off", 32'(i2c_buf_en), 0);
      chk("R8 dead clear", 32'(dead), 0);

      // R10 all pins inverted
      @(negedge clk);
      cfg_inv = 4'hF; mp_good_pin = 1'b0; pp_good_pin = 1'b1;
      cyc(5);
      chk("R10 mp_en idle high", 32'(mp_en_pin), 1);
      chk("R10 pp_en idle high", 32'(pp_en_pin), 1);
      chk("R10 i2c not inverted", 32'(i2c_buf_en), 0);
      push(3'd1, 1'b0, "R10 insert");
      push(3'd2, 1'b0, "R10 handle");
      pres(1'b1); cyc(20);
      chk("R10 mp_en active low", 32'(mp_en_pin), 0);
      push(3'd3, 1'b0, "R10 activate");
      pulse_act(); cyc(2);
      chk("R10 pp_en active low", 32'(pp_en_pin), 0);
      chk("R10 i2c high", 32'(i2c_buf_en), 1);
      push(3'd4, 1'b0, "R10 pp good low");
      pp_good_pin = 1'b0; cyc(6);
      chk("R10 in M4", 32'(mstate), 4);
      push(3'd0, 1'b1, "R7 mp loss inverted");
      mp_good_pin = 1'b1; cyc(6);
      chk("R7 dead from M4", 32'(dead), 1);
      chk("R10 mp_en back high", 32'(mp_en_pin), 1);

      cyc(10);
      chk("scoreboard drained", 32'(q_st.size()), 0);
      done = 1'b1;
      summary();
   end
endmodule